// File: doc/BRIEF.md
# Prescaled Reload Delay Timer

This block is a delay timer. A programmable prescaler divides the system clock. Each of its count pulses decrements an 8-bit main counter. When the counter is at 01 and a count pulse arrives, the counter does not go to 00. It is reloaded from a time-constant register instead. That same reload raises a one-cycle interrupt strobe and flips a square-wave output, so one output period spans two timeouts.

Software drives the timer through a small register port with two addresses.

- **Control register:** holds a 3-bit divisor code. Code zero stops the timer. Any write to this register forces the wave output low.
- **Data register:** a write sets the time constant. It also loads the counter, but only while the timer is stopped. A read returns the live count.

The timer runs on the system clock, so bus accesses and counting share one domain.

Top module: `dly_timer`

## Requirements
- R1: After reset the divisor code is 0 (stopped) and the count is 0. `tick_irq` and `wave_out` are low. A control read returns 0 and a data read returns 0.
- R2: The divisor code sits in control bits [2:0]. Codes 1 to 7 select divisors of 4, 10, 16, 50, 64, 100 and 200. A control write of a nonzero code at edge E0 with constant C (1 to 255) gives `tick_irq` after edges E0+N·C, E0+2·N·C and so on. N is the divisor, and a divisor of 10 with C=100 gives a timeout every 1000 cycles.
- R3: Each prescaler count pulse decrements the count by one while the count is above 01.
- R4: A count pulse arriving while the count is 01 reloads the counter from the time constant. It also raises `tick_irq` for exactly one cycle, starting the cycle after that edge.
- R5: A time constant of 00 gives one timeout every 256 count pulses. The count passes through 255 after the reload.
- R6: `wave_out` flips on the same edge that raises `tick_irq`.
- R7: A data write while stopped loads both the constant and the count. A data write while running changes only the constant, which is used at the next reload. A running write that coincides with a reload is the value reloaded.
- R8: While stopped, the count holds its value and the prescaler residue is discarded. Every control write restarts the prescaler from zero, so the first pulse after a start comes N cycles later.
- R9: A control write forces `wave_out` low on its edge. This wins over a timeout toggle on the same edge.
- R10: A read strobe at edge E returns data on `bus_rdata` from E onward. A data read returns the count as it stood before E. A control read returns the code in bits [2:0], with zeros above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 1 | 0 selects the control register, 1 selects the data register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tick_irq | output | 1 | One-cycle timeout strobe |
| wave_out | output | 1 | Square wave, toggled by each timeout |

## Verification
Counting from the edge E0 that takes a start write, the k-th timeout appears on `tick_irq` and `wave_out` just after edge E0+k·N·C. The bench queues exactly those edge numbers and compares each observed strobe against the head of the queue on the falling edge that follows. Read data is due one edge after the strobe and holds the pre-edge count, so reads are deliberately placed on prescaler pulse edges. When the timer stops, expected stopped counts come from the number of pulse edges up to and including the stop edge. Queue entries beyond a control write are dropped at that write.

// File: rtl/dly_timer_pkg.sv
package dly_timer_pkg;
  localparam int CODE_W = 3;
  localparam int PRE_W  = 8;

  // divisor selected by a control code; code 0 means stopped
  function automatic logic [PRE_W-1:0] divisor_of(input logic [CODE_W-1:0] code);
    case (code)
      3'd1:    divisor_of = PRE_W'(4);
      3'd2:    divisor_of = PRE_W'(10);
      3'd3:    divisor_of = PRE_W'(16);
      3'd4:    divisor_of = PRE_W'(50);
      3'd5:    divisor_of = PRE_W'(64);
      3'd6:    divisor_of = PRE_W'(100);
      3'd7:    divisor_of = PRE_W'(200);
      default: divisor_of = '0;
    endcase
  endfunction

  // terminal prescaler value for a code
  function automatic logic [PRE_W-1:0] limit_of(input logic [CODE_W-1:0] code);
    limit_of = divisor_of(code) - PRE_W'(1);
  endfunction
endpackage

// File: rtl/dly_timer_prescaler.sv
module dly_timer_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] limit,
  output logic             pulse
);
  logic [PRE_W-1:0] pre_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_cnt <= '0;
    else if (!run || restart)  pre_cnt <= '0;
    else if (pre_cnt == limit) pre_cnt <= '0;
    else                       pre_cnt <= pre_cnt + PRE_W'(1);
  end

  assign pulse = run && (pre_cnt == limit);

  // R8: a stopped prescaler keeps no residue
  assert_residue_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_cnt == '0));

  // R2: divisors are at least 4, so pulses never come back to back
  assert_pulse_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/dly_timer_counter.sv
module dly_timer_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pulse,
  input  logic         run,
  input  logic         data_wr,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] count,
  output logic         timeout
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] tc;
  logic [W-1:0] reload_val;

  assign reload_val = data_wr ? data_in : tc;
  assign timeout    = pulse && (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tc <= '0;
    else if (data_wr) tc <= data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count <= '0;
    else if (timeout)         count <= reload_val;
    else if (pulse)           count <= count - ONE;
    else if (data_wr && !run) count <= data_in;
  end

  // R4: a timeout reloads the stored constant
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !data_wr) |=> (count == $past(tc)));

  // R3: a pulse above 01 steps the count down by one
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && count > ONE) |=> (count == $past(count) - ONE));

  // R8: a stopped timer without a data write holds its count
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !data_wr) |=> $stable(count));
endmodule

// File: rtl/dly_timer.sv
module dly_timer
  import dly_timer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tick_irq,
  output logic              wave_out
);
  localparam int PAD_W = DATA_W - CODE_W;

  logic [CODE_W-1:0] code_q;
  logic              ctrl_wr;
  logic              data_wr;
  logic              run;
  logic              pulse;
  logic              timeout;
  logic [DATA_W-1:0] count;
  logic [PRE_W-1:0]  limit;

  assign ctrl_wr = bus_wr && !bus_sel;
  assign data_wr = bus_wr && bus_sel;
  assign run     = (code_q != '0);
  assign limit   = limit_of(code_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (ctrl_wr) code_q <= bus_wdata[CODE_W-1:0];
  end

  dly_timer_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (ctrl_wr),
    .limit   (limit),
    .pulse   (pulse)
  );

  dly_timer_counter #(.W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse   (pulse),
    .run     (run),
    .data_wr (data_wr),
    .data_in (bus_wdata),
    .count   (count),
    .timeout (timeout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_irq <= 1'b0;
      wave_out <= 1'b0;
    end else begin
      tick_irq <= timeout;
      if (ctrl_wr)      wave_out <= 1'b0;
      else if (timeout) wave_out <= !wave_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= bus_sel ? count : {{PAD_W{1'b0}}, code_q};
  end

  // R9: a control write leaves the wave low
  assert_force_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !wave_out);

  // R6: each strobe comes with a wave flip unless forced low
  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_irq && !$past(ctrl_wr)) |-> (wave_out != $past(wave_out)));

  // R4: the strobe lasts one cycle
  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |=> !tick_irq);
endmodule

// File: tb/dly_timer_bench.sv
`timescale 1ns/1ps
module dly_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_sel = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       tick_irq;
  logic       wave_out;

  dly_timer u_dly_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_irq(tick_irq), .wave_out(wave_out)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int   n_checks = 0;
  int   n_fail = 0;
  int   exp_q[$];
  logic exp_wave = 1'b0;
  int   last_ctrl = -1;
  bit   done = 0;
  int   v;
  int   t, t2, t3;
  int   div_tab[8] = '{0, 4, 10, 16, 50, 64, 100, 200};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor: every strobe must match the next queued edge
  always @(negedge clk) begin
    if (rst_n && tick_irq) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected strobe", cyc, -1);
      end else begin
        check(cyc == exp_q[0], "R2 strobe edge", cyc, exp_q[0]);
        void'(exp_q.pop_front());
      end
      exp_wave = (last_ctrl == cyc) ? 1'b0 : ~exp_wave;
      check(wave_out == exp_wave, "R6 wave", int'(wave_out), int'(exp_wave));
    end
  end

  task automatic at(input int e);
    while (cyc < e - 1) @(negedge clk);
  endtask

  task automatic wr_ctrl(input int e, input int code);
    at(e);
    bus_wr = 1'b1; bus_sel = 1'b0; bus_wdata = 8'(code);
    @(posedge clk); #1;
    bus_wr = 1'b0;
    last_ctrl = e;
    exp_wave = 1'b0;
    while (exp_q.size() > 0 && exp_q[$] > e) void'(exp_q.pop_back());
    @(negedge clk);
    check(wave_out == 1'b0, "R9 forced low", int'(wave_out), 0);
  endtask

  task automatic wr_data(input int e, input int val);
    at(e);
    bus_wr = 1'b1; bus_sel = 1'b1; bus_wdata = 8'(val);
    @(posedge clk); #1;
    bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input int e, input bit sel, output int val);
    at(e);
    bus_rd = 1'b1; bus_sel = sel;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    @(negedge clk);
    val = int'(bus_rdata);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check(wave_out == 1'b0, "R1 wave", int'(wave_out), 0);
    check(tick_irq == 1'b0, "R1 strobe", int'(tick_irq), 0);
    rd(cyc + 1, 1'b0, v); check(v == 0, "R1 control read", v, 0);
    rd(cyc + 1, 1'b1, v); check(v == 0, "R1 count read", v, 0);

    // R7: stopped write loads the count
    wr_data(cyc + 1, 3);
    rd(cyc + 1, 1'b1, v); check(v == 3, "R7 stopped load", v, 3);

    // start with divisor 4, constant 3
    t = cyc + 1;
    wr_ctrl(t, 1);
    exp_q.push_back(t + 12); exp_q.push_back(t + 24);
    rd(t + 1, 1'b0, v); check(v == 1, "R10 control read", v, 1);
    rd(t + 4, 1'b1, v); check(v == 3, "R10 pre-edge count", v, 3);
    rd(t + 5, 1'b1, v); check(v == 2, "R3 decrement", v, 2);
    rd(t + 9, 1'b1, v); check(v == 1, "R3 decrement", v, 1);
    wr_data(t + 14, 5);
    rd(t + 15, 1'b1, v); check(v == 3, "R7 running write keeps count", v, 3);
    exp_q.push_back(t + 44); exp_q.push_back(t + 64);
    wr_ctrl(t + 70, 0);
    rd(t + 80, 1'b1, v); check(v == 4, "R8 held count", v, 4);

    // R8: restart discards prescaler residue
    t2 = t + 90;
    wr_ctrl(t2, 1);
    exp_q.push_back(t2 + 16); exp_q.push_back(t2 + 36);
    // R9: control write on the strobe edge wins
    t3 = t2 + 36;
    wr_ctrl(t3, 1);
    exp_q.push_back(t3 + 20);
    wr_ctrl(t3 + 22, 0);

    // R5: constant 00 gives 256 pulses per timeout
    wr_data(cyc + 1, 0);
    t = cyc + 1;
    wr_ctrl(t, 1);
    exp_q.push_back(t + 1024); exp_q.push_back(t + 2048);
    rd(t + 1030, 1'b1, v); check(v == 255, "R5 wrap after reload", v, 255);
    wr_ctrl(t + 2050, 0);
    rd(cyc + 1, 1'b1, v); check(v == 0, "R5 reload of zero", v, 0);

    // R2: every divisor with constant 1
    for (int c = 1; c < 8; c++) begin
      wr_data(cyc + 1, 1);
      t = cyc + 1;
      wr_ctrl(t, c);
      exp_q.push_back(t + div_tab[c]); exp_q.push_back(t + 2 * div_tab[c]);
      wr_ctrl(t + 2 * div_tab[c] + 1, 0);
    end

    // R2: divisor 10, constant 100 -> 1000 cycles
    wr_data(cyc + 1, 100);
    t = cyc + 1;
    wr_ctrl(t, 2);
    exp_q.push_back(t + 1000);
    wr_ctrl(t + 1001, 0);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R4 missing strobes", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule